// File: doc/BRIEF.md
# Bidirectional Logical Shifter with Carry

This block shifts a 32-bit word left or right by a distance taken from a single signed count operand. The low seven bits of the count word form a two's-complement number from -64 to +63. A positive value shifts toward the most significant end and a negative value shifts toward the least significant end. In both directions the vacated positions fill with zeros. The last bit pushed off the edge of the word becomes the new carry flag.

An execution stage presents a source word, a count word and the current carry flag together with a valid strobe. One clock edge later the block presents the shifted word, the updated carry flag, a zero status bit, a negative status bit and a one-cycle result-valid strobe. The outputs hold their values until the next strobe. The source operand is only read. The shifted value appears only on the result port.

Top module: `bishift_unit`

## Requirements
- R1: Only bits [6:0] of `count_word` are used, read as a two's-complement value from -64 to +63. Bits [31:7] have no effect on any output.
- R2: A count n in 1..63 gives `result` = `src_word` shifted left by n, with zeros entering at bit 0. For n of 32 or more, `result` is all zeros.
- R3: A count -m, with m in 1..64, gives `result` = `src_word` shifted right by m, with zeros entering at bit 31. For m of 32 or more, `result` is all zeros.
- R4: For a shift distance d in 1..32, `carry_out` is the last bit shifted out. On a left shift this is `src_word`[32-d]. On a right shift it is `src_word`[d-1].
- R5: For a shift distance greater than 32 in either direction, `carry_out` is 0.
- R6: A count of zero passes `src_word` to `result` unchanged and copies `carry_in` to `carry_out`.
- R7: `zero_flag` is 1 exactly when the 32-bit `result` is all zeros. `neg_flag` equals `result`[31].
- R8: The outputs update on the clock edge that samples `in_valid` high. On that edge `out_valid` rises, and it stays high for one cycle for each strobe. Without a strobe, `result`, `carry_out` and the flags keep their values.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand strobe |
| src_word | input | 32 | Word to be shifted |
| count_word | input | 32 | Count word; bits [6:0] hold the signed shift count |
| carry_in | input | 1 | Present carry flag, kept when the count is zero |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | Updated carry flag |
| zero_flag | output | 1 | Result is all zeros |
| neg_flag | output | 1 | Copy of result bit 31 |

## Verification
Every fault in the direction decode, the magnitude negation or one of the barrel stages shows up at the ports one edge after the strobe that uses it. The bench therefore compares every result against a separate reference, for every count from -64 to +63. A stuck or skipped barrel stage damages only those counts whose magnitude has that bit set, so the full count sweep is what catches it. Carry faults can hide behind all-ones or all-zeros sources, so single-bit sources are run as well. A faulty clock enable shows on the first idle cycle as a result that changes without a strobe.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 7;
  localparam int CWORD_W = 32;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              carry;
    logic              zero;
    logic              neg;
  } sft_out_t;
endpackage

// File: rtl/sft_count_decode.sv
module sft_count_decode #(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             is_neg,
  output logic             is_zero,
  output logic [CNT_W-1:0] mag
);
  // Count is two's complement; the most negative value's magnitude still fits unsigned
  always_comb begin
    is_neg  = cnt[CNT_W-1];
    is_zero = (cnt == '0);
    mag     = is_neg ? (~cnt + 1'b1) : cnt;
  end
endmodule

// File: rtl/sft_barrel.sv
module sft_barrel #(
  parameter int W  = 33,
  parameter int SW = 7
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [SW+1];

  assign stg[0] = din;

  // One left-shift stage per magnitude bit; weights past the width empty the word
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    if (STEP >= W) begin : g_flush
      assign stg[k+1] = amt[k] ? '0 : stg[k];
    end else begin : g_shift
      assign stg[k+1] = amt[k] ? {stg[k][W-1-STEP:0], {STEP{1'b0}}} : stg[k];
    end
  end

  assign dout = stg[SW];
endmodule

// File: rtl/bishift_unit.sv
module bishift_unit
  import sft_pkg::*;
#(
  parameter int DW = sft_pkg::DATA_W,
  parameter int CW = sft_pkg::CNT_W,
  parameter int WW = sft_pkg::CWORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] src_word,
  input  logic [WW-1:0] count_word,
  input  logic          carry_in,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          carry_out,
  output logic          zero_flag,
  output logic          neg_flag
);
  localparam int GW = DW + 1;  // data plus one guard bit that catches the carry

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  logic          c_neg, c_zero;
  logic [CW-1:0] c_mag;

  sft_count_decode #(.CNT_W(CW)) u_dec (
    .cnt     (count_word[CW-1:0]),
    .is_neg  (c_neg),
    .is_zero (c_zero),
    .mag     (c_mag)
  );

  // A right shift is a left shift of the bit-reversed word
  function automatic logic [GW-1:0] rev_bits(input logic [GW-1:0] v);
    logic [GW-1:0] r;
    for (int i = 0; i < GW; i++) r[i] = v[GW-1-i];
    return r;
  endfunction

  logic [GW-1:0] bar_in, bar_out, bar_fix;

  always_comb begin
    if (c_neg) bar_in = rev_bits({src_word, 1'b0});
    else       bar_in = {1'b0, src_word};
  end

  sft_barrel #(.W(GW), .SW(CW)) u_bar (
    .din  (bar_in),
    .amt  (c_mag),
    .dout (bar_out)
  );

  assign bar_fix = c_neg ? rev_bits(bar_out) : bar_out;

  sft_out_t nxt, cur;
  logic     vld_q;

  // Next-state logic
  always_comb begin
    if (c_zero) begin
      nxt.data  = src_word;
      nxt.carry = carry_in;
    end else if (c_neg) begin
      nxt.data  = bar_fix[GW-1:1];
      nxt.carry = bar_fix[0];
    end else begin
      nxt.data  = bar_fix[DW-1:0];
      nxt.carry = bar_fix[DW];
    end
    nxt.zero = (nxt.data == '0);
    nxt.neg  = nxt.data[DW-1];
  end

  // Registers with explicit enable
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cur   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) cur <= nxt;
    end
  end

  assign out_valid = vld_q;
  assign result    = cur.data;
  assign carry_out = cur.carry;
  assign zero_flag = cur.zero;
  assign neg_flag  = cur.neg;
endmodule

// File: rtl/bishift_unit_chk.sv
module bishift_unit_chk #(
  parameter int DW = 32,
  parameter int CW = 7,
  parameter int WW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] src_word,
  input logic [WW-1:0] count_word,
  input logic          carry_in,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic          carry_out,
  input logic          zero_flag,
  input logic          neg_flag
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry_out))); // R8
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zero_flag == (result == '0))); // R7
  AST_NEG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (neg_flag == result[DW-1])); // R7
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && count_word[CW-1:0] == '0) |=>
      (result == $past(src_word) && carry_out == $past(carry_in))); // R6
  AST_FAR_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !count_word[CW-1] && count_word[CW-2:0] > 32) |=>
      (result == '0 && !carry_out)); // R5
  AST_FAR_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && count_word[CW-1] && $signed(count_word[CW-1:0]) < -32) |=>
      (result == '0 && !carry_out)); // R5
endmodule

bind bishift_unit bishift_unit_chk #(.DW(DW), .CW(CW), .WW(WW)) u_chk (.*);

// File: tb/tb_bishift_unit.sv
`timescale 1ns/1ps
module tb_bishift_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] src_word;
  logic [31:0] count_word;
  logic        carry_in;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out, zero_flag, neg_flag;

  always #2 clk = ~clk;  // 250 MHz

  bishift_unit dut (.*);

  typedef struct {
    logic [31:0] data;
    logic        carry;
    int          cnt;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  bit   have_last = 0;
  bit   monitor_on = 0;
  bit   done = 0;
  int   checks = 0;
  int   errors = 0;

  function automatic exp_t ref_model(logic [31:0] s, logic [31:0] cw, logic ci);
    exp_t e;
    logic [63:0] w;
    int c;
    c = int'($signed(cw[6:0]));
    e.cnt = c;
    if (c == 0) begin
      e.data = s; e.carry = ci;
    end else if (c > 0) begin
      w = {32'b0, s} << c;
      e.data = w[31:0]; e.carry = w[32];
    end else begin
      w = {s, 32'b0} >> (-c);
      e.data = w[63:32]; e.carry = w[31];
    end
    return e;
  endfunction

  function automatic string tag_of(int c);
    if (c == 0) return "R6";
    if (c > 32 || c < -32) return "R5";
    if (c > 0) return "R2 R4";
    return "R3 R4";
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic drive(logic [31:0] s, logic [31:0] cw, logic ci);
    @(negedge clk);
    in_valid = 1'b1; src_word = s; count_word = cw; carry_in = ci;
    exp_q.push_back(ref_model(s, cw, ci));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; src_word = $urandom; count_word = $urandom; carry_in = $urandom;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (monitor_on) begin
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            check(0, "R8", "unexpected out_valid", 1, 0);
          end else begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_of(e.cnt);
            check(result == e.data, t, $sformatf("result cnt=%0d", e.cnt), result, e.data);
            check(carry_out == e.carry, t, $sformatf("carry cnt=%0d", e.cnt), carry_out, e.carry);
            check(zero_flag == (e.data == 0), "R7", "zero_flag", zero_flag, e.data == 0);
            check(neg_flag == e.data[31], "R7", "neg_flag", neg_flag, e.data[31]);
            last_exp = e; have_last = 1;
          end
        end else if (have_last) begin
          check(result == last_exp.data && carry_out == last_exp.carry, "R8",
                "hold while idle", {31'b0, carry_out, result}, {31'b0, last_exp.carry, last_exp.data});
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_word = '1; count_word = 32'h1; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    // R9: outputs cleared during reset
    check({out_valid, result, carry_out, zero_flag, neg_flag} == '0, "R9", "reset state",
          {out_valid, result, carry_out, zero_flag, neg_flag}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    monitor_on = 1;

    // Full count sweep with varied sources; upper count bits random (R1)
    for (int c = -64; c < 64; c++) begin
      logic [31:0] cw;
      cw = {$urandom, 7'(c)} ;
      drive($urandom, cw, $urandom);
      drive(32'hFFFF_FFFF, {25'($urandom), 7'(c)}, $urandom);
      drive(32'h1 << ((c + 64) % 32), {25'h0, 7'(c)}, $urandom);
      drive(32'h8000_0001, {25'h1FF_FFFF, 7'(c)}, 1'b0);
      if (c % 16 == 0) idle(2);
    end

    // R1: same low bits, different upper bits, identical outcome from the bench model
    drive(32'h1234_5678, 32'hFFFF_FF83, 1'b0);
    drive(32'h1234_5678, 32'h0000_0003, 1'b0);
    // R6: zero count keeps both carry values
    drive(32'hDEAD_BEEF, 32'hABCD_EF80, 1'b1);
    drive(32'hDEAD_BEEF, 32'h0, 1'b0);
    // R4 boundary: distance exactly 32 each way
    drive(32'h0000_0001, 32'd32, 1'b0);
    drive(32'h8000_0000, {25'h0, 7'h60}, 1'b0);
    idle(3);
    // R9: asynchronous reset clears outputs again
    @(negedge clk); monitor_on = 0; rst_n = 1'b0;
    #1;
    check({out_valid, result, carry_out, zero_flag, neg_flag} == '0, "R9", "reset mid-run",
          {out_valid, result, carry_out, zero_flag, neg_flag}, 0);
    check(exp_q.size() == 0, "R8", "pending results", exp_q.size(), 0);
    idle(2);
    finish_run();
  end
endmodule